// File: doc/BRIEF.md
# Integer Arithmetic Unit with Extension Output

This block is the integer execution unit of a small processor core. Each accepted operation takes two 32-bit operands, B and C, a group bit and a 3-bit operation code. It returns a primary 32-bit result and, for arithmetic and shift operations, a second 32-bit word meant for a dedicated extension register. That second word is the carry or borrow of an add or subtract, the upper half of a product, the remainder of a division, or the bits that a shift pushes out.

Most operations finish in one cycle. Multiply and divide run on small iterative engines and hold `busy` high for a fixed number of cycles. A division by zero finishes at once: it returns all ones in both words and raises an exception request that carries a fixed code.

Operations come in on a valid/ready handshake. `in_ready` is the inverse of `busy`. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. When `in_valid` is high while `in_ready` is low, nothing is queued or remembered. The caller must hold or re-present the operation. The output side has no back-pressure. `out_valid` is high for exactly one cycle per operation, and `out_res`, `out_ext` and `out_ext_we` keep their values until the next completion.

Top module: `xalu`

## Requirements
- R1: Add (group 0, code 0) gives `out_res` = (B+C) mod 2^32. `out_ext` is the carry of the unsigned sum, 0 or 1, and `out_ext_we`=1.
- R2: Subtract (group 0, code 1) gives `out_res` = (B-C) mod 2^32. `out_ext` is the upper word of B plus the 32-bit negation of C, both zero-extended, so it is 1 exactly when C is nonzero and B>=C unsigned. `out_ext_we`=1.
- R3: Multiply (group 0, code 2) holds `busy` high for exactly 9 cycles. It then gives the low word of the unsigned 64-bit product in `out_res` and the high word in `out_ext`.
- R4: Divide (group 0, code 3) with C nonzero is signed and truncates toward zero. It holds `busy` high for exactly 39 cycles, then gives the quotient in `out_res` and the remainder B-(B/C)*C in `out_ext`.
- R5: Divide with C=0 completes the next cycle without `busy`. It sets `out_res` and `out_ext` to all ones, `out_ext_we`=1, and pulses `exc_valid` together with `out_valid` with `exc_code`=258.
- R6: Logical right shift (group 1, code 1) and arithmetic right shift (group 1, code 3) shift B by C[4:0]. `out_ext` holds the bits shifted out, aligned to bit 31, and is 0 when the amount is 0.
- R7: Left shift (group 1, code 2) shifts B left by C[4:0]. `out_ext` holds the bits shifted out of bit 31, aligned to bit 0, and is 0 when the amount is 0.
- R8: Compare (group 1, code 7) is signed. It returns 32'hFFFFFFFF if B<C, 0 if B=C and 1 if B>C, with `out_ext_we`=0.
- R9: Group 0 codes 4, 5, 6 and 7 give B AND C, B OR C, B XOR C and NOT C. Each completes the cycle after acceptance with `out_ext_we`=0.
- R10: Every single-cycle operation raises `out_valid` in the cycle after acceptance. A multi-cycle operation raises `out_valid`, with its new result, in the first cycle that `busy` is low again.
- R11: An operation offered while `busy` is high is ignored: it changes neither the outputs nor the timing of the operation in progress.
- R12: While reset is active, `busy`, `out_valid` and `exc_valid` are 0.
- R13: The unassigned group 1 codes 0, 4, 5 and 6 complete in one cycle with `out_res`=0 and `out_ext_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_grp | input | 1 | Group select: 0 plain arithmetic and logic, 1 shifts and compare |
| in_op | input | 3 | Operation code within the group |
| in_b | input | 32 | Operand B |
| in_c | input | 32 | Operand C |
| busy | output | 1 | Multi-cycle operation in progress |
| out_valid | output | 1 | One-cycle pulse: result words updated |
| out_res | output | 32 | Primary result |
| out_ext | output | 32 | Value for the extension register |
| out_ext_we | output | 1 | The extension register is to be written with `out_ext` |
| exc_valid | output | 1 | One-cycle exception request |
| exc_code | output | 16 | Exception code, 258 for division by zero |

## Verification
The checker assumes that the group, code and operands are known values in every cycle where `in_valid` is high. It also assumes that the cycle-count parameters leave each iterative engine at least one spare cycle to finish. The bench drives fully defined values in every cycle, including cycles with `in_valid` low. It keeps the default cycle counts. It never offers the most-negative dividend with a divisor of -1, because that quotient does not fit in 32 bits and its value is not fixed by the requirements. In the random phase, `in_valid` often stays high across busy windows, so ignored offers occur constantly. The reference model accepts only the offers that should be taken.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
  // Operation code is {group, op}
  typedef enum logic [3:0] {
    K_ADD = 4'h0, K_SUB = 4'h1, K_MUL = 4'h2, K_DIV = 4'h3,
    K_AND = 4'h4, K_OR  = 4'h5, K_XOR = 4'h6, K_NOT = 4'h7,
    K_SRL = 4'h9, K_SLL = 4'hA, K_SRA = 4'hB, K_CMP = 4'hF
  } alu_op_e;
endpackage

// File: rtl/xalu_comb.sv
module xalu_comb
  import xalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   code,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] res,
  output logic [W-1:0] ext,
  output logic         ext_we,
  output logic         is_mul,
  output logic         is_div,
  output logic         div_zero
);
  localparam int AMT_W = $clog2(W);

  logic [AMT_W-1:0] amt;
  logic [W-1:0]     neg_c;
  logic [2*W-1:0]   sum_add, sum_sub, sh_left, sh_right;
  logic [W-1:0]     sra_res;

  assign amt      = c[AMT_W-1:0];
  assign neg_c    = -c;
  assign sum_add  = {{W{1'b0}}, b} + {{W{1'b0}}, c};
  assign sum_sub  = {{W{1'b0}}, b} + {{W{1'b0}}, neg_c};
  assign sh_left  = {{W{1'b0}}, b} << amt;
  assign sh_right = {b, {W{1'b0}}} >> amt;
  assign sra_res  = $signed(b) >>> amt;

  always_comb begin
    res      = '0;
    ext      = '0;
    ext_we   = 1'b0;
    is_mul   = 1'b0;
    is_div   = 1'b0;
    div_zero = 1'b0;
    case (alu_op_e'(code))
      K_ADD: begin res = sum_add[W-1:0]; ext = sum_add[2*W-1:W]; ext_we = 1'b1; end
      K_SUB: begin res = sum_sub[W-1:0]; ext = sum_sub[2*W-1:W]; ext_we = 1'b1; end
      K_MUL: is_mul = 1'b1;
      K_DIV: begin
        if (c == '0) begin
          res = '1; ext = '1; ext_we = 1'b1; div_zero = 1'b1;
        end else begin
          is_div = 1'b1;
        end
      end
      K_AND: res = b & c;
      K_OR:  res = b | c;
      K_XOR: res = b ^ c;
      K_NOT: res = ~c;
      K_SRL: begin res = sh_right[2*W-1:W]; ext = sh_right[W-1:0]; ext_we = 1'b1; end
      K_SRA: begin res = sra_res;           ext = sh_right[W-1:0]; ext_we = 1'b1; end
      K_SLL: begin res = sh_left[W-1:0];    ext = sh_left[2*W-1:W]; ext_we = 1'b1; end
      K_CMP: begin
        if ($signed(b) < $signed(c)) res = '1;
        else if (b == c)             res = '0;
        else                         res = W'(1);
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/xalu_mul.sv
module xalu_mul #(
  parameter int W   = 32,
  parameter int DIG = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi
);
  localparam int STEPS  = W / DIG;
  localparam int STEP_W = $clog2(STEPS + 1);

  logic [2*W-1:0]    acc, mcand;
  logic [W-1:0]      mplier;
  logic [STEP_W-1:0] left;
  logic [2*W-1:0]    partial;

  // one digit of the multiplier per cycle
  assign partial = mcand * {{(2*W-DIG){1'b0}}, mplier[DIG-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      left   <= '0;
    end else if (load) begin
      acc    <= '0;
      mcand  <= {{W{1'b0}}, b};
      mplier <= c;
      left   <= STEP_W'(STEPS);
    end else if (left != '0) begin
      acc    <= acc + partial;
      mcand  <= mcand << DIG;
      mplier <= mplier >> DIG;
      left   <= left - STEP_W'(1);
    end
  end

  assign prod_lo = acc[W-1:0];
  assign prod_hi = acc[2*W-1:W];
endmodule

// File: rtl/xalu_div.sv
module xalu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int STEP_W = $clog2(W + 1);

  logic [W-1:0]      q_mag, r_mag, den;
  logic              neg_q, neg_r;
  logic [STEP_W-1:0] left;
  logic [W:0]        shifted, diff;

  assign shifted = {r_mag, q_mag[W-1]};
  assign diff    = shifted - {1'b0, den};

  // restoring division on magnitudes, one quotient bit per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_mag <= '0;
      r_mag <= '0;
      den   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
      left  <= '0;
    end else if (load) begin
      q_mag <= b[W-1] ? -b : b;
      den   <= c[W-1] ? -c : c;
      r_mag <= '0;
      neg_q <= b[W-1] ^ c[W-1];
      neg_r <= b[W-1];
      left  <= STEP_W'(W);
    end else if (left != '0) begin
      if (!diff[W]) begin
        r_mag <= diff[W-1:0];
        q_mag <= {q_mag[W-2:0], 1'b1};
      end else begin
        r_mag <= shifted[W-1:0];
        q_mag <= {q_mag[W-2:0], 1'b0};
      end
      left <= left - STEP_W'(1);
    end
  end

  assign quo = neg_q ? -q_mag : q_mag;
  assign rem = neg_r ? -r_mag : r_mag;
endmodule

// File: rtl/xalu.sv
module xalu #(
  parameter int W       = 32,
  parameter int MUL_DIG = 4,
  parameter int MUL_CYC = 9,
  parameter int DIV_CYC = 39,
  parameter int EXC_W   = 16,
  parameter int EXC_DZ  = 258
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_grp,
  input  logic [2:0]       in_op,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     in_c,
  output logic             busy,
  output logic             out_valid,
  output logic [W-1:0]     out_res,
  output logic [W-1:0]     out_ext,
  output logic             out_ext_we,
  output logic             exc_valid,
  output logic [EXC_W-1:0] exc_code
);
  // engines need MUL_CYC > W/MUL_DIG and DIV_CYC > W to finish in time
  localparam int MAX_CYC = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [W-1:0]     c_res, c_ext, m_lo, m_hi, d_quo, d_rem;
  logic             c_we, c_mul, c_div, c_dz, accept, sel_div;
  logic [CNT_W-1:0] cnt;

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;

  xalu_comb #(.W(W)) comb_i (
    .code(({in_grp, in_op})), .b(in_b), .c(in_c),
    .res(c_res), .ext(c_ext), .ext_we(c_we),
    .is_mul(c_mul), .is_div(c_div), .div_zero(c_dz)
  );

  xalu_mul #(.W(W), .DIG(MUL_DIG)) mul_i (
    .clk(clk), .rst_n(rst_n), .load(accept && c_mul),
    .b(in_b), .c(in_c), .prod_lo(m_lo), .prod_hi(m_hi)
  );

  xalu_div #(.W(W)) div_i (
    .clk(clk), .rst_n(rst_n), .load(accept && c_div),
    .b(in_b), .c(in_c), .quo(d_quo), .rem(d_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      sel_div    <= 1'b0;
      out_valid  <= 1'b0;
      out_res    <= '0;
      out_ext    <= '0;
      out_ext_we <= 1'b0;
      exc_valid  <= 1'b0;
      exc_code   <= '0;
    end else begin
      out_valid <= 1'b0;
      exc_valid <= 1'b0;
      if (busy) begin
        if (cnt == CNT_W'(1)) begin
          busy       <= 1'b0;
          out_valid  <= 1'b1;
          out_res    <= sel_div ? d_quo : m_lo;
          out_ext    <= sel_div ? d_rem : m_hi;
          out_ext_we <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end else if (accept) begin
        if (c_mul || c_div) begin
          busy    <= 1'b1;
          sel_div <= c_div;
          cnt     <= c_div ? CNT_W'(DIV_CYC) : CNT_W'(MUL_CYC);
        end else begin
          out_valid  <= 1'b1;
          out_res    <= c_res;
          out_ext    <= c_ext;
          out_ext_we <= c_we;
          exc_valid  <= c_dz;
          if (c_dz) exc_code <= EXC_W'(EXC_DZ);
        end
      end
    end
  end
endmodule

// File: rtl/xalu_chk.sv
module xalu_chk #(
  parameter int W       = 32,
  parameter int MUL_CYC = 9,
  parameter int DIV_CYC = 39,
  parameter int EXC_W   = 16,
  parameter int EXC_DZ  = 258
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_grp,
  input logic [2:0]       in_op,
  input logic             busy,
  input logic             out_valid,
  input logic [W-1:0]     out_res,
  input logic [W-1:0]     out_ext,
  input logic             out_ext_we,
  input logic             exc_valid,
  input logic [EXC_W-1:0] exc_code
);
  localparam int RUN_W = $clog2(((MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC) + 2);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + RUN_W'(1);
    else           run <= '0;
  end

  // R3 and R4: busy window has one of the two fixed lengths
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == RUN_W'(MUL_CYC) || run == RUN_W'(DIV_CYC)));

  a_r5_dz_values: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (out_valid && exc_code == EXC_W'(EXC_DZ) && (&out_res) && (&out_ext)));

  a_r9_logic_next: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && !in_grp && in_op[2]) |=> (out_valid && !busy && !out_ext_we));

  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (out_valid && out_ext_we));

  a_r11_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(out_res) && $stable(out_ext) && !out_valid));
endmodule

bind xalu xalu_chk #(
  .W(W), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC), .EXC_W(EXC_W), .EXC_DZ(EXC_DZ)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_grp(in_grp), .in_op(in_op),
  .busy(busy), .out_valid(out_valid), .out_res(out_res), .out_ext(out_ext),
  .out_ext_we(out_ext_we), .exc_valid(exc_valid), .exc_code(exc_code)
);

// File: tb/xalu_tb_top.sv
`timescale 1ns/1ps
module xalu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_grp = 1'b0;
  logic [2:0]  in_op = '0;
  logic [31:0] in_b = '0, in_c = '0;
  logic        busy, out_valid, out_ext_we, exc_valid;
  logic [31:0] out_res, out_ext;
  logic [15:0] exc_code;

  always #10 clk = ~clk;

  xalu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_grp(in_grp), .in_op(in_op), .in_b(in_b), .in_c(in_c),
    .busy(busy), .out_valid(out_valid), .out_res(out_res), .out_ext(out_ext),
    .out_ext_we(out_ext_we), .exc_valid(exc_valid), .exc_code(exc_code)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference for one operation
  function automatic void ref_op(input bit g, input bit [2:0] o, input bit [31:0] b, c,
                                 output bit [31:0] r, e, output bit we, ex,
                                 output int lat, output string tag);
    bit [63:0] wide;
    int amt;
    amt = c % 32;
    r = 0; e = 0; we = 0; ex = 0; lat = 0; tag = "R13";
    if (!g) begin
      case (o)
        0: begin wide = 64'(b) + 64'(c); r = wide[31:0]; e = wide[63:32]; we = 1; tag = "R1"; end
        1: begin wide = 64'(b) + 64'(32'(0 - c)); r = b - c; e = wide[63:32]; we = 1; tag = "R2"; end
        2: begin wide = 64'(b) * 64'(c); r = wide[31:0]; e = wide[63:32]; we = 1; lat = 9; tag = "R3"; end
        3: begin
          we = 1;
          if (c == 0) begin r = '1; e = '1; ex = 1; tag = "R5"; end
          else begin r = $signed(b) / $signed(c); e = $signed(b) % $signed(c); lat = 39; tag = "R4"; end
        end
        4: begin r = b & c; tag = "R9"; end
        5: begin r = b | c; tag = "R9"; end
        6: begin r = b ^ c; tag = "R9"; end
        default: begin r = ~c; tag = "R9"; end
      endcase
    end else begin
      case (o)
        1: begin r = b >> amt; e = (amt == 0) ? 0 : b << (32 - amt); we = 1; tag = "R6"; end
        3: begin r = $signed(b) >>> amt; e = (amt == 0) ? 0 : b << (32 - amt); we = 1; tag = "R6"; end
        2: begin r = b << amt; e = (amt == 0) ? 0 : b >> (32 - amt); we = 1; tag = "R7"; end
        7: begin
          tag = "R8";
          if ($signed(b) < $signed(c)) r = 32'hFFFF_FFFF;
          else if (b == c) r = 0;
          else r = 1;
        end
        default: ;
      endcase
    end
  endfunction

  // reference model state, advanced on each rising edge
  int m_left = 0;
  bit [31:0] p_res, p_ext, e_res, e_ext;
  bit p_we, p_ex, e_we, e_ex, e_valid = 0;
  string p_tag, e_tag;

  always @(posedge clk) begin : model
    bit acc;
    bit [31:0] r, e;
    bit we, ex;
    int lat;
    string tag;
    cyc++;
    if (!rst_n) begin
      m_left = 0;
      e_valid = 0;
    end else begin
      acc = in_valid && (m_left == 0);  // R11: offers while busy are dropped
      e_valid = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          e_valid = 1; e_res = p_res; e_ext = p_ext; e_we = p_we; e_ex = p_ex; e_tag = p_tag;
        end
      end
      if (acc) begin
        ref_op(in_grp, in_op, in_b, in_c, r, e, we, ex, lat, tag);
        if (lat == 0) begin
          e_valid = 1; e_res = r; e_ext = e; e_we = we; e_ex = ex; e_tag = tag;
        end else begin
          m_left = lat; p_res = r; p_ext = e; p_we = we; p_ex = ex; p_tag = tag;
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      if (cyc >= 1)
        chk(!busy && !out_valid && !exc_valid, "R12", "reset state",
            {29'd0, busy, out_valid, exc_valid}, 32'd0);
    end else if (!done) begin
      chk(busy == (m_left != 0), "R10/R11", "busy", 32'(busy), 32'(m_left != 0));
      chk(out_valid == e_valid, "R10", "out_valid", 32'(out_valid), 32'(e_valid));
      if (out_valid && e_valid) begin
        chk(out_res == e_res, e_tag, "result", out_res, e_res);
        chk(out_ext_we == e_we, e_tag, "ext write", 32'(out_ext_we), 32'(e_we));
        if (e_we) chk(out_ext == e_ext, e_tag, "ext value", out_ext, e_ext);
        chk(exc_valid == e_ex, e_tag, "exception", 32'(exc_valid), 32'(e_ex));
        if (e_ex) chk(exc_code == 16'd258, "R5", "exc code", 32'(exc_code), 32'd258);
      end
    end
  end

  task automatic send(input bit g, input bit [2:0] o, input bit [31:0] b, c);
    @(negedge clk);
    in_valid = 1; in_grp = g; in_op = o; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    send(0, 0, 32'hFFFF_FFFF, 32'h1);          // R1 carry out
    send(0, 0, 32'h1234_5678, 32'h1111_1111);  // R1 no carry
    send(0, 1, 32'h5, 32'h9);                  // R2 borrow case
    send(0, 1, 32'h9, 32'h5);                  // R2
    send(0, 1, 32'h7, 32'h0);                  // R2 C zero
    send(0, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R3
    send(0, 2, 32'h0001_0000, 32'h0003_0000);  // R3
    send(0, 3, 32'hFFFF_FFF9, 32'h2);          // R4 -7/2
    send(0, 3, 32'd100, 32'hFFFF_FFFD);        // R4 100/-3
    send(0, 3, 32'd12345, 32'd0);              // R5
    send(0, 4, 32'hF0F0_F0F0, 32'hFF00_FF00);  // R9
    send(0, 7, 32'h0, 32'h0F0F_0000);          // R9 not
    send(1, 1, 32'h8000_0001, 32'd0);          // R6 amount 0
    send(1, 1, 32'h8000_0003, 32'd35);         // R6 amount from low bits
    send(1, 3, 32'h8000_0003, 32'd31);         // R6 arithmetic
    send(1, 2, 32'hC000_0001, 32'd2);          // R7
    send(1, 2, 32'hC000_0001, 32'd0);          // R7 amount 0
    send(1, 7, 32'hFFFF_FFFF, 32'd1);          // R8 less
    send(1, 7, 32'd5, 32'd5);                  // R8 equal
    send(1, 7, 32'd6, 32'hFFFF_FFFE);          // R8 greater
    send(1, 5, 32'd6, 32'd7);                  // R13
    // random phase: valid often held through busy windows (R11)
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      in_valid = ($urandom % 3) != 0;
      in_grp = 1'($urandom);
      in_op = 3'($urandom);
      in_b = $urandom;
      in_c = (($urandom % 4) == 0) ? ($urandom % 3) : $urandom;
      if (!in_grp && in_op == 3 && in_b == 32'h8000_0000 && in_c == 32'hFFFF_FFFF) in_b = 1;
    end
    @(negedge clk);
    in_valid = 0;
    repeat (50) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule